// File: doc/BRIEF.md
# Page Translation Unit with Hardware Table Walk

This block maps each virtual address presented by a requester to a physical address. The address is split in two: the upper bits form the virtual page number and the lower bits form the offset within the page. The page number is compared against every slot of a small fully associative translation cache. On a match, the cached frame number is joined with the unchanged offset and the request completes.

When no slot matches, the block fetches the page-table entry for that page from memory through a simple read handshake. The entry can lead to one of three outcomes:

- An entry whose mapping is invalid ends the request with a segmentation fault.
- A mapped entry whose page is not resident ends it with a page fault.
- A usable entry is written into the cache, and the lookup is then run again.

A write to a page whose entry forbids writing ends with a protection fault. The requester holds its request until a one-cycle completion pulse, and only one table read is ever outstanding. A flush input invalidates the whole cache in one cycle.

Top module: `xlat_unit`

## Requirements
- R1: After reset, no completion pulse and no memory read are issued, and the cache holds no entries, so the first access to any page causes a table read.
- R2: When the lookup hits and no fault applies, the cycle after the request is seen shows a one-cycle completion pulse with fault code 0. The physical address is the cached frame number in the upper bits and the request's offset (the low OFF_W bits, 8 by default) in the lower bits.
- R3: On a miss, the block raises a memory read at address pt_base + page_number * PTE_BYTES (2 by default) and holds that address until the read data is marked valid. Entry fields: frame number in bits [PFN_W-1:0]; valid flag at bit PFN_W; present flag at PFN_W+1; read, write and execute permissions at PFN_W+2, PFN_W+3 and PFN_W+4.
- R4: An entry that is valid and present is written into the cache, and the lookup is retried, which completes the request. Later accesses to that page complete without a table read.
- R5: An entry whose valid flag is clear completes the request with fault code 1 and physical address 0, and nothing is cached. This holds whatever its present flag says.
- R6: An entry that is valid but has its present flag clear completes the request with fault code 2 and physical address 0, and nothing is cached.
- R7: A write that hits a cached page whose write permission is clear completes with fault code 3 and physical address 0. A read of the same page completes normally.
- R8: Refills use the cache slots in rotating order, starting at slot 0 after reset, and each refill evicts the oldest filled slot.
- R9: A flush pulse invalidates every cached entry within one cycle, so the next access to any page performs a table read.
- R10: When a flush falls in the same cycle as a refill, the flush wins and the refill is discarded. The retried lookup then misses and reads the table again before completing.
- R11: When a flush falls in the same cycle as a hit lookup, that lookup uses the contents from before the flush and completes without a table read. The following access to that page misses.
- R12: The completion pulse lasts exactly one cycle. A request still held in the cycle of the pulse is ignored in that cycle, and no completion coincides with an outstanding memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request present; held until resp_done |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for a write access |
| pt_base | input | PT_AW | Page-table base address |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_pa | output | PFN_W+OFF_W | Physical address, valid with resp_done |
| resp_fault | output | 2 | 0 none, 1 segmentation, 2 page, 3 protection |
| mem_rd_req | output | 1 | Table read request, held until mem_rd_valid |
| mem_rd_addr | output | PT_AW | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | PTE_W | Page-table entry |

## Verification
Two operations can land on the same clock edge: a flush can coincide with a refill at the end of a table read, and a flush can coincide with a hit lookup. The bench produces the first by having its memory model raise flush in the very cycle it returns the entry. It produces the second by asserting flush together with a new request to a page that is already cached. In the refill case the bench expects two table reads for one request, followed by a miss on a page cached earlier. In the lookup case it expects a completion without a table read, followed by a miss on the next access. A behavioural model is compared against every output on every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Fault codes seen by the requester on resp_fault
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PAGE = 2'd2,
    FLT_PROT = 2'd3
  } flt_e;

  // Control sequencer states
  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  // Decoded page-table entry flags
  typedef struct packed {
    logic vld;
    logic prs;
    logic rd;
    logic wr;
    logic ex;
  } pte_flags_t;

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int N     = 8,
  parameter int VPN_W = 8,
  parameter int PFN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr
);

  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             vld_q, vld_d;
  logic [N-1:0][VPN_W-1:0]  tag_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;
  logic [N-1:0]             wr_q;
  logic [PTR_W-1:0]         ptr_q, ptr_d;
  logic [N-1:0]             match;
  logic [N-1:0]             wsel;
  logic                     fill_go;

  // flush takes priority over a refill arriving in the same cycle
  assign fill_go = fill_en && !flush;

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      assign match[g] = vld_q[g] && (tag_q[g] == vpn);
      assign wsel[g]  = fill_go && (ptr_q == PTR_W'(g));
    end
  endgenerate

  assign lk_hit = |match;

  // one-hot OR mux of the matching slot
  always_comb begin
    lk_pfn = '0;
    lk_wr  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        lk_pfn = lk_pfn | pfn_q[i];
        lk_wr  = lk_wr  | wr_q[i];
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_go) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  // payload storage, written only through its slot enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wsel[i]) begin
        tag_q[i] <= vpn;
        pfn_q[i] <= fill_pfn;
        wr_q[i]  <= fill_wr;
      end
    end
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFF_W     = 8,
  parameter int PFN_W     = 8,
  parameter int PT_AW     = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_write,
  input  logic [PT_AW-1:0]       pt_base,
  output logic [VA_W-OFF_W-1:0]  vpn,
  input  logic                   lk_hit,
  input  logic [PFN_W-1:0]       lk_pfn,
  input  logic                   lk_wr,
  output logic                   fill_en,
  output logic [PFN_W-1:0]       fill_pfn,
  output logic                   fill_wr,
  output logic                   mem_rd_req,
  output logic [PT_AW-1:0]       mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [PTE_W-1:0]       mem_rd_data,
  output logic                   resp_done,
  output logic [PFN_W+OFF_W-1:0] resp_pa,
  output logic [1:0]             resp_fault
);

  localparam int PA_W  = PFN_W + OFF_W;
  localparam int V_BIT = PFN_W;
  localparam int P_BIT = PFN_W + 1;
  localparam int R_BIT = PFN_W + 2;
  localparam int W_BIT = PFN_W + 3;
  localparam int X_BIT = PFN_W + 4;

  st_e              st_q, st_d;
  logic             done_q, done_d;
  flt_e             flt_q, flt_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             mrq_q, mrq_d;
  logic [PT_AW-1:0] madr_q, madr_d;
  logic             madr_en;
  logic [PT_AW-1:0] pte_addr;
  pte_flags_t       pf;
  logic             unused_pte;

  assign vpn      = req_va[VA_W-1:OFF_W];
  assign pte_addr = pt_base + (PT_AW'(vpn) * PT_AW'(PTE_BYTES));

  assign pf.vld = mem_rd_data[V_BIT];
  assign pf.prs = mem_rd_data[P_BIT];
  assign pf.rd  = mem_rd_data[R_BIT];
  assign pf.wr  = mem_rd_data[W_BIT];
  assign pf.ex  = mem_rd_data[X_BIT];
  assign unused_pte = ^{pf.rd, pf.ex, mem_rd_data};

  // refill when a usable entry comes back
  assign fill_en  = (st_q == ST_WALK) && mem_rd_valid && pf.vld && pf.prs;
  assign fill_pfn = mem_rd_data[PFN_W-1:0];
  assign fill_wr  = pf.wr;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    flt_d   = FLT_NONE;
    pa_d    = '0;
    mrq_d   = mrq_q;
    madr_d  = madr_q;
    madr_en = 1'b0;
    unique case (st_q)
      ST_LOOK: begin
        if (req_valid) begin
          if (lk_hit) begin
            done_d = 1'b1;
            st_d   = ST_RESP;
            if (req_write && !lk_wr) begin
              flt_d = FLT_PROT;
            end else begin
              pa_d = {lk_pfn, req_va[OFF_W-1:0]};
            end
          end else begin
            mrq_d   = 1'b1;
            madr_d  = pte_addr;
            madr_en = 1'b1;
            st_d    = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (mem_rd_valid) begin
          mrq_d = 1'b0;
          if (!pf.vld) begin
            done_d = 1'b1;
            flt_d  = FLT_SEG;
            st_d   = ST_RESP;
          end else if (!pf.prs) begin
            done_d = 1'b1;
            flt_d  = FLT_PAGE;
            st_d   = ST_RESP;
          end else begin
            st_d = ST_LOOK;
          end
        end
      end
      ST_RESP: begin
        st_d = ST_LOOK;
      end
      default: begin
        st_d  = ST_LOOK;
        mrq_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOOK;
      done_q <= 1'b0;
      flt_q  <= FLT_NONE;
      pa_q   <= '0;
      mrq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      flt_q  <= flt_d;
      pa_q   <= pa_d;
      mrq_q  <= mrq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      madr_q <= '0;
    end else if (madr_en) begin
      madr_q <= madr_d;
    end
  end

  assign resp_done   = done_q;
  assign resp_pa     = pa_q;
  assign resp_fault  = flt_q;
  assign mem_rd_req  = mrq_q;
  assign mem_rd_addr = madr_q;

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int VA_W      = 16,
  parameter int OFF_W     = 8,
  parameter int PFN_W     = 8,
  parameter int PT_AW     = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2,
  parameter int TLB_N     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_write,
  input  logic [PT_AW-1:0]       pt_base,
  output logic                   resp_done,
  output logic [PFN_W+OFF_W-1:0] resp_pa,
  output logic [1:0]             resp_fault,
  output logic                   mem_rd_req,
  output logic [PT_AW-1:0]       mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [PTE_W-1:0]       mem_rd_data
);

  localparam int VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0] vpn;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_wr;
  logic             fill_en;
  logic [PFN_W-1:0] fill_pfn;
  logic             fill_wr;

  xlat_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
    .PT_AW(PT_AW), .PTE_W(PTE_W), .PTE_BYTES(PTE_BYTES)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_va      (req_va),
    .req_write   (req_write),
    .pt_base     (pt_base),
    .vpn         (vpn),
    .lk_hit      (lk_hit),
    .lk_pfn      (lk_pfn),
    .lk_wr       (lk_wr),
    .fill_en     (fill_en),
    .fill_pfn    (fill_pfn),
    .fill_wr     (fill_wr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_data (mem_rd_data),
    .resp_done   (resp_done),
    .resp_pa     (resp_pa),
    .resp_fault  (resp_fault)
  );

  xlat_tlb #(
    .N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) i_tlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .vpn     (vpn),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .lk_wr   (lk_wr),
    .fill_en (fill_en),
    .fill_pfn(fill_pfn),
    .fill_wr (fill_wr)
  );

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int PFN_W = 8,
  parameter int PT_AW = 16,
  parameter int PTE_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [VA_W-1:0]        req_va,
  input logic                   resp_done,
  input logic [PFN_W+OFF_W-1:0] resp_pa,
  input logic [1:0]             resp_fault,
  input logic                   mem_rd_req,
  input logic [PT_AW-1:0]       mem_rd_addr,
  input logic                   mem_rd_valid,
  input logic [PTE_W-1:0]       mem_rd_data
);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_no_done_during_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !resp_done);

  assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_fault == 2'd0) |-> (resp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

  // faulted completions carry no address (R5, R6, R7)
  assert_fault_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_fault != 2'd0) |-> (resp_pa == '0));

  assert_invalid_segfault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && !mem_rd_data[PFN_W]) |=> (resp_done && resp_fault == 2'd1));

  assert_absent_pagefault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && mem_rd_data[PFN_W] && !mem_rd_data[PFN_W+1])
      |=> (resp_done && resp_fault == 2'd2));

  assert_refill_retries_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && mem_rd_data[PFN_W] && mem_rd_data[PFN_W+1])
      |=> (!resp_done && !mem_rd_req));

endmodule

bind xlat_unit xlat_unit_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PT_AW(PT_AW), .PTE_W(PTE_W)
) i_xlat_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_va      (req_va),
  .resp_done   (resp_done),
  .resp_pa     (resp_pa),
  .resp_fault  (resp_fault),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_data (mem_rd_data)
);

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;

  logic        clk;
  logic        rst_n;
  logic        flush, flush_tb, flush_mem;
  logic        req_valid;
  logic [15:0] req_va;
  logic        req_write;
  logic [15:0] pt_base;
  logic        resp_done;
  logic [15:0] resp_pa;
  logic [1:0]  resp_fault;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [15:0] mem_rd_data;

  assign flush = flush_tb | flush_mem;

  xlat_unit i_xlat_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_va(req_va), .req_write(req_write), .pt_base(pt_base),
    .resp_done(resp_done), .resp_pa(resp_pa), .resp_fault(resp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          n_run = 0;
  int          n_fail = 0;
  string       cur_tag = "R1";
  logic [15:0] pt [256];
  int          mem_lat = 1;
  int          mem_cnt = 0;
  bit          flush_on_fill = 0;
  int          walk_cnt = 0;
  logic [15:0] last_walk_addr = 16'h0;
  bit          prev_mreq = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pte(input int pfn, input bit v, input bit p, input bit r, input bit w, input bit x);
    return {3'b000, x, w, r, p, v, 8'(pfn)};
  endfunction

  // memory model for page-table reads
  always @(negedge clk) begin
    flush_mem = 1'b0;
    if (mem_rd_req && !prev_mreq) begin
      walk_cnt++;
      last_walk_addr = mem_rd_addr;
    end
    prev_mreq = mem_rd_req;
    if (mem_rd_req) begin
      if (mem_cnt >= mem_lat) begin
        int idx;
        idx = int'(mem_rd_addr - pt_base) >> 1;
        mem_rd_valid = 1'b1;
        mem_rd_data  = (idx >= 0 && idx < 256) ? pt[idx] : 16'h0;
        if (flush_on_fill) begin
          flush_mem = 1'b1;
          flush_on_fill = 0;
        end
      end else begin
        mem_rd_valid = 1'b0;
      end
      mem_cnt++;
    end else begin
      mem_cnt = 0;
      mem_rd_valid = 1'b0;
    end
  end

  // behavioural reference model
  int          ms;
  bit          md, mq;
  logic [1:0]  mf;
  logic [15:0] mpa, ma;
  bit          tv [8];
  int          tvp [8];
  int          tpf [8];
  bit          tw [8];
  int          mptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; md = 0; mq = 0; mf = 0; mpa = 0; ma = 0; mptr = 0;
      for (int i = 0; i < 8; i++) tv[i] = 0;
    end else begin
      bit nd;
      logic [1:0] nf;
      logic [15:0] npa;
      int cur;
      nd = 0; nf = 0; npa = 0; cur = ms;
      if (cur == 0) begin
        if (req_valid) begin
          int hit;
          hit = -1;
          for (int i = 0; i < 8; i++) if (tv[i] && tvp[i] == int'(req_va[15:8])) hit = i;
          if (hit >= 0) begin
            nd = 1; ms = 2;
            if (req_write && !tw[hit]) nf = 3;
            else npa = {8'(tpf[hit]), req_va[7:0]};
          end else begin
            mq = 1; ma = 16'(pt_base + req_va[15:8] * 2); ms = 1;
          end
        end
      end else if (cur == 1) begin
        if (mem_rd_valid) begin
          mq = 0;
          if (!mem_rd_data[8]) begin nd = 1; nf = 1; ms = 2; end
          else if (!mem_rd_data[9]) begin nd = 1; nf = 2; ms = 2; end
          else begin
            if (!flush) begin
              tv[mptr] = 1; tvp[mptr] = int'(req_va[15:8]);
              tpf[mptr] = int'(mem_rd_data[7:0]); tw[mptr] = mem_rd_data[11];
              mptr = (mptr + 1) % 8;
            end
            ms = 0;
          end
        end
      end else begin
        ms = 0;
      end
      if (flush) for (int i = 0; i < 8; i++) tv[i] = 0;
      md = nd; mf = nf; mpa = npa;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, "model done", {31'b0, resp_done}, {31'b0, md});
      chk(cur_tag, "model fault", {30'b0, resp_fault}, {30'b0, mf});
      chk(cur_tag, "model pa", {16'b0, resp_pa}, {16'b0, mpa});
      chk(cur_tag, "model mem_rd_req", {31'b0, mem_rd_req}, {31'b0, mq});
      if (mq) chk(cur_tag, "model mem_rd_addr", {16'b0, mem_rd_addr}, {16'b0, ma});
    end
  end

  task automatic access(input logic [15:0] va, input bit wr, input bit fl,
                        input logic [1:0] exp_f, input logic [15:0] exp_pa,
                        input int exp_walks, input string tag);
    int w0;
    int cyc;
    cur_tag = tag;
    @(negedge clk);
    w0 = walk_cnt;
    req_va = va; req_write = wr; req_valid = 1'b1; flush_tb = fl;
    @(negedge clk);
    flush_tb = 1'b0;
    cyc = 0;
    while (!resp_done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!resp_done) begin
      n_run++; n_fail++;
      $display("FAIL %s no completion actual=0 expected=1", tag);
    end else begin
      chk(tag, "fault", {30'b0, resp_fault}, {30'b0, exp_f});
      chk(tag, "pa", {16'b0, resp_pa}, {16'b0, exp_pa});
      chk(tag, "walks", 32'(walk_cnt - w0), 32'(exp_walks));
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_tb = 1'b0; flush_mem = 1'b0;
    req_valid = 1'b0; req_va = 16'h0; req_write = 1'b0;
    pt_base = 16'h1000; mem_rd_valid = 1'b0; mem_rd_data = 16'h0;
    for (int i = 0; i < 256; i++) pt[i] = 16'h0;
    pt[1] = pte(8'h21, 1, 1, 1, 1, 0);
    pt[2] = pte(8'h32, 1, 1, 1, 0, 1);
    pt[3] = pte(8'h45, 1, 0, 1, 1, 0);
    pt[4] = pte(8'h55, 0, 1, 1, 1, 0);
    for (int v = 10; v <= 20; v++) pt[v] = pte(v + 8'h40, 1, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'b0, resp_done}, 32'd0);
    chk("R1", "read in reset", {31'b0, mem_rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "done after reset", {31'b0, resp_done}, 32'd0);
    chk("R1", "read after reset", {31'b0, mem_rd_req}, 32'd0);

    // R1 / R3 / R4: first access misses, walks, refills, retries
    access(16'h0155, 0, 0, 2'd0, 16'h2155, 1, "R4");
    chk("R3", "walk address", {16'b0, last_walk_addr}, 32'h1002);
    access(16'h01F0, 1, 0, 2'd0, 16'h21F0, 0, "R2");
    mem_lat = 3;
    access(16'h0207, 0, 0, 2'd0, 16'h3207, 1, "R2");
    chk("R3", "walk address", {16'b0, last_walk_addr}, 32'h1004);
    access(16'h0207, 1, 0, 2'd3, 16'h0000, 0, "R7");
    access(16'h02AB, 0, 0, 2'd0, 16'h32AB, 0, "R7");
    access(16'h0300, 0, 0, 2'd2, 16'h0000, 1, "R6");
    access(16'h0311, 1, 0, 2'd2, 16'h0000, 1, "R6");
    mem_lat = 0;
    access(16'h0400, 0, 0, 2'd1, 16'h0000, 1, "R5");
    access(16'h04EE, 0, 0, 2'd1, 16'h0000, 1, "R5");
    mem_lat = 2;

    // R8: slots 2..7 take pages 10..15, page 16 evicts page 1 from slot 0
    for (int v = 10; v <= 15; v++) access(16'((v << 8) | 8'h3C), 0, 0, 2'd0, 16'(((v + 8'h40) << 8) | 8'h3C), 1, "R8");
    access(16'h1000, 0, 0, 2'd0, 16'h5000, 1, "R8");
    access(16'h0201, 0, 0, 2'd0, 16'h3201, 0, "R8");
    access(16'h0102, 0, 0, 2'd0, 16'h2102, 1, "R8");
    access(16'h0203, 0, 0, 2'd0, 16'h3203, 1, "R8");
    access(16'h0B04, 0, 0, 2'd0, 16'h4B04, 0, "R8");

    // R9: idle flush empties the cache
    cur_tag = "R9";
    @(negedge clk); flush_tb = 1'b1;
    @(negedge clk); flush_tb = 1'b0;
    access(16'h0B05, 0, 0, 2'd0, 16'h4B05, 1, "R9");
    access(16'h0106, 0, 0, 2'd0, 16'h2106, 1, "R9");

    // R10: flush lands on the refill cycle
    flush_on_fill = 1;
    access(16'h0C07, 0, 0, 2'd0, 16'h4C07, 2, "R10");
    access(16'h0B08, 0, 0, 2'd0, 16'h4B08, 1, "R10");
    access(16'h0C09, 0, 0, 2'd0, 16'h4C09, 0, "R10");

    // R11: flush lands on a hit lookup
    access(16'h0C0A, 1, 1, 2'd0, 16'h4C0A, 0, "R11");
    access(16'h0C0B, 0, 0, 2'd0, 16'h4C0B, 1, "R11");

    // R12: request held past the completion pulse
    cur_tag = "R12";
    @(negedge clk);
    req_va = 16'h0C0C; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk("R12", "first completion", {31'b0, resp_done}, 32'd1);
    @(negedge clk);
    chk("R12", "pulse width", {31'b0, resp_done}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12", "no repeat after drop", {31'b0, resp_done}, 32'd0);
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule